// File: doc/BRIEF.md
# Lockable Power-Mode Control Register

This block is a single 16-bit system control register on a plain synchronous register bus: a write strobe, a write data word and a read data word. Software uses it to decide whether the core's STOP and WAIT instructions really take the chip into the matching low-power mode. It also triggers a device reset from software and forces the debug clock to the core on.

Each mode has a 2-bit field. The low bit of the field blocks entry into that mode. The high bit makes the field freeze itself until the next system reset. A boot routine can therefore fix the power policy once, and no code that runs later can change it. The outputs are two entry grants that gate the core's requests, a single-cycle software-reset pulse for the reset sequencer, and a debug clock enable. Clock gating, reset sequencing and the core itself are not part of this block.

Top module: `pmc_ctrl_reg`

## Requirements
- R1: After system reset `rd_data` reads 0x0000, no field is locked, `swrst_pulse` is low, and both grants follow their requests.
- R2: Bits 15 to 6 always read as 0, and writing ones to them changes no other bit and no output.
- R3: Bit 5 is the debug clock bit. It is stored on every write and reads back as written. `dbg_clk_en` equals bit 5 OR `tap_en`.
- R4: When a write has bit 4 set, `swrst_pulse` is high for exactly the one cycle after that write edge, unless the next cycle is also such a write. Bit 4 always reads as 0.
- R5: Bits 3:2 form the stop field. `stop_grant` equals `stop_req` AND NOT bit 2. Codes 00 and 10 allow stop entry; codes 01 and 11 block it.
- R6: Bits 1:0 form the wait field. `wait_grant` equals `wait_req` AND NOT bit 0, with the same code meanings as R5.
- R7: A write that stores a code with its high bit set (10 or 11) locks that field. Later writes leave the field unchanged.
- R8: A write that reaches a locked field still updates the debug bit and any unlocked field in the same cycle.
- R9: A lock stays set through any number of writes. Only system reset clears it, and after reset the field is writable again.
- R10: Both grants follow a change of request or of field value in the same cycle, with no register stage between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 16 | Write data word |
| rd_data | output | 16 | Current register value |
| stop_req | input | 1 | Core request to enter stop mode |
| wait_req | input | 1 | Core request to enter wait mode |
| tap_en | input | 1 | Core test-access port is enabled |
| stop_grant | output | 1 | Stop-mode entry allowed |
| wait_grant | output | 1 | Wait-mode entry allowed |
| swrst_pulse | output | 1 | Single-cycle software reset request |
| dbg_clk_en | output | 1 | Debug clock to the core enabled |

## Verification
A field that takes a write after it has locked shows on `rd_data` and on its grant as soon as the next edge has passed. The bench therefore reads the field back right after every write that should have been rejected. A lock that is missing or does not hold is visible only after a later write, so each lock test writes the opposite code and then checks both the field and the grant. A late or lasting reset pulse shows on `swrst_pulse` one cycle after the write, and the bench samples it in that cycle and in the cycle after.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int REG_W     = 16;
  localparam int FIELD_W   = 2;
  localparam int NUM_MODES = 2;
  localparam int DBG_BIT   = 5;
  localparam int SWRST_BIT = 4;
  localparam int USED_W    = DBG_BIT + 1;

  // mode index: 0 = wait (bits 1:0), 1 = stop (bits 3:2)
  localparam int MODE_WAIT = 0;
  localparam int MODE_STOP = 1;

  function automatic int field_lsb(input int mode);
    return mode * FIELD_W;
  endfunction

  function automatic logic code_blocks(input logic [FIELD_W-1:0] code);
    return code[0];
  endfunction

  function automatic logic code_locks(input logic [FIELD_W-1:0] code);
    return code[FIELD_W-1];
  endfunction

  function automatic logic entry_grant(input logic req,
                                       input logic [FIELD_W-1:0] code);
    return req & ~code_blocks(code);
  endfunction

endpackage

// File: rtl/pmc_mode_field.sv
module pmc_mode_field
  import pmc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_code,
  input  logic               req,
  output logic [FIELD_W-1:0] code,
  output logic               locked,
  output logic               grant,
  output logic               wr_rejected
);

  logic take_write;

  assign take_write  = wr_en & ~locked;
  assign wr_rejected = wr_en & locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code   <= '0;
      locked <= 1'b0;
    end else if (take_write) begin
      code   <= wr_code;
      locked <= code_locks(wr_code);
    end
  end

  assign grant = entry_grant(req, code);

endmodule

// File: rtl/pmc_swrst_gen.sv
module pmc_swrst_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= fire;
  end

endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             stop_req,
  input  logic             wait_req,
  input  logic             tap_en,
  output logic             stop_grant,
  output logic             wait_grant,
  output logic             swrst_pulse,
  output logic             dbg_clk_en
);

  logic [NUM_MODES-1:0]              req_vec;
  logic [NUM_MODES-1:0]              grant_vec;
  logic [NUM_MODES-1:0]              locked_vec;
  logic [NUM_MODES-1:0]              rejected_vec;
  logic [NUM_MODES-1:0][FIELD_W-1:0] code_vec;
  logic                              dbg_q;
  logic                              swrst_fire;
  logic                              stop_locked;
  logic                              wait_locked;
  logic                              reserved_unused;

  assign req_vec[MODE_STOP] = stop_req;
  assign req_vec[MODE_WAIT] = wait_req;

  genvar m;
  generate
    for (m = 0; m < NUM_MODES; m++) begin : g_mode
      pmc_mode_field u_field (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_code     (wr_data[field_lsb(m) +: FIELD_W]),
        .req         (req_vec[m]),
        .code        (code_vec[m]),
        .locked      (locked_vec[m]),
        .grant       (grant_vec[m]),
        .wr_rejected (rejected_vec[m])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dbg_q <= 1'b0;
    else if (wr_en) dbg_q <= wr_data[DBG_BIT];
  end

  assign swrst_fire = wr_en & wr_data[SWRST_BIT];

  pmc_swrst_gen u_swrst (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (swrst_fire),
    .pulse (swrst_pulse)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_MODES; i++)
      rd_data[field_lsb(i) +: FIELD_W] = code_vec[i];
    rd_data[DBG_BIT] = dbg_q;
  end

  assign stop_grant      = grant_vec[MODE_STOP];
  assign wait_grant      = grant_vec[MODE_WAIT];
  assign dbg_clk_en      = dbg_q | tap_en;
  assign stop_locked     = locked_vec[MODE_STOP];
  assign wait_locked     = locked_vec[MODE_WAIT];
  assign reserved_unused = ^{wr_data[REG_W-1:USED_W], rejected_vec};

endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk
  import pmc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_swrst,
  input logic [1:0]       wr_stop,
  input logic [1:0]       wr_wait,
  input logic [REG_W-1:0] rd_data,
  input logic             stop_req,
  input logic             wait_req,
  input logic             tap_en,
  input logic             stop_grant,
  input logic             wait_grant,
  input logic             swrst_pulse,
  input logic             dbg_clk_en,
  input logic             stop_locked,
  input logic             wait_locked
);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:USED_W] == '0);

  a_r4_swrst_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[SWRST_BIT] == 1'b0);

  a_r4_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_swrst) |=> swrst_pulse);

  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_swrst) |=> !swrst_pulse);

  a_r3_dbg_enable: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_clk_en == (rd_data[DBG_BIT] || tap_en));

  a_r5_stop_grant: assert property (@(posedge clk) disable iff (!rst_n)
    stop_grant == (stop_req && !rd_data[2]));

  a_r6_wait_grant: assert property (@(posedge clk) disable iff (!rst_n)
    wait_grant == (wait_req && !rd_data[0]));

  a_r7_stop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stop_locked |=> $stable(rd_data[3:2]));

  a_r7_wait_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wait_locked |=> $stable(rd_data[1:0]));

  a_r9_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stop_locked |=> stop_locked);

  a_r9_wait_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wait_locked |=> wait_locked);

  a_r8_stop_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stop_locked) |=> rd_data[3:2] == $past(wr_stop));

  a_r8_wait_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wait_locked) |=> rd_data[1:0] == $past(wr_wait));

endmodule

bind pmc_ctrl_reg pmc_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_swrst    (wr_data[4]),
  .wr_stop     (wr_data[3:2]),
  .wr_wait     (wr_data[1:0]),
  .rd_data     (rd_data),
  .stop_req    (stop_req),
  .wait_req    (wait_req),
  .tap_en      (tap_en),
  .stop_grant  (stop_grant),
  .wait_grant  (wait_grant),
  .swrst_pulse (swrst_pulse),
  .dbg_clk_en  (dbg_clk_en),
  .stop_locked (stop_locked),
  .wait_locked (wait_locked)
);

// File: tb/test_pmc_ctrl_reg.sv
module test_pmc_ctrl_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        stop_req = 1'b0;
  logic        wait_req = 1'b0;
  logic        tap_en = 1'b0;
  logic        stop_grant;
  logic        wait_grant;
  logic        swrst_pulse;
  logic        dbg_clk_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  pmc_ctrl_reg i_pmc_ctrl_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .stop_req    (stop_req),
    .wait_req    (wait_req),
    .tap_en      (tap_en),
    .stop_grant  (stop_grant),
    .wait_grant  (wait_grant),
    .swrst_pulse (swrst_pulse),
    .dbg_clk_en  (dbg_clk_en)
  );

  // {wdata, stop_req, wait_req, tap_en, exp_rd, exp_sg, exp_wg, exp_dbg, pad}
  localparam int NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {16'h0000, 3'b110, 16'h0000, 3'b110, 2'b00},
    {16'hFFC0, 3'b110, 16'h0000, 3'b110, 2'b00},
    {16'h0020, 3'b110, 16'h0020, 3'b111, 2'b00},
    {16'h0005, 3'b111, 16'h0005, 3'b001, 2'b00},
    {16'h0004, 3'b110, 16'h0004, 3'b010, 2'b00},
    {16'h0001, 3'b110, 16'h0001, 3'b100, 2'b00},
    {16'h0000, 3'b000, 16'h0000, 3'b000, 2'b00},
    {16'hFFD0, 3'b110, 16'h0000, 3'b110, 2'b00}
  };

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] wv;
    logic [2:0]  rq;
    logic [15:0] er;
    logic [2:0]  eo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    stop_req = 1'b1;
    wait_req = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rd_data", rd_data, 16'h0000);
    check("R1 grants", {14'd0, stop_grant, wait_grant}, 16'h0003);
    check("R1 pulse", {15'd0, swrst_pulse}, 16'h0000);

    // R2 R3 R5 R6 R10: vector table
    for (int i = 0; i < NV; i++) begin
      {wv, rq, er, eo} = VEC[i][39:2];
      stop_req = rq[2];
      wait_req = rq[1];
      tap_en   = rq[0];
      write(wv);
      #1;
      check("R2/R3/R5/R6 vector rd_data", rd_data, er);
      check("R5/R6/R3 vector outputs",
            {13'd0, stop_grant, wait_grant, dbg_clk_en}, {13'd0, eo});
    end
    tap_en = 1'b0;

    // R4: pulse timing and readback
    write(16'h0010);
    check("R4 pulse in cycle after write", {15'd0, swrst_pulse}, 16'h0001);
    check("R4 bit reads zero", rd_data, 16'h0000);
    @(negedge clk);
    check("R4 pulse lasts one cycle", {15'd0, swrst_pulse}, 16'h0000);

    // R10: grants follow request in same cycle
    write(16'h0000);
    stop_req = 1'b0;
    wait_req = 1'b1;
    #1;
    check("R10 grant follows request", {14'd0, stop_grant, wait_grant}, 16'h0001);
    stop_req = 1'b1;
    #1;
    check("R10 grant follows request rise", {14'd0, stop_grant, wait_grant}, 16'h0003);

    // R7 R8: lock stop (10), wait left unlocked (01)
    write(16'h0009);
    check("R7 lock write stored", rd_data, 16'h0009);
    write(16'h0026);
    check("R8 locked stop kept, wait and dbg updated", rd_data, 16'h002A);
    write(16'h0007);
    check("R7 both locked, dbg cleared", rd_data, 16'h000A);
    check("R7 grants with locked allow codes",
          {14'd0, stop_grant, wait_grant}, 16'h0003);

    // R9: reset clears locks
    do_reset();
    check("R9 reset clears value", rd_data, 16'h0000);
    write(16'h0005);
    check("R9 fields writable after reset", rd_data, 16'h0005);

    // R7: blocking lock code 11 holds
    write(16'h000C);
    write(16'h0000);
    check("R7 stop 11 locked", rd_data, 16'h000C);
    check("R7 stop blocked after lock", {14'd0, stop_grant, wait_grant}, 16'h0001);
    write(16'h0000);
    check("R9 lock survives repeated writes", rd_data, 16'h000C);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule